// File: doc/BRIEF.md
# I2C Master SCL Bit Timing Generator

This block turns bit-level requests from an I2C master command engine into bus waveforms. It drives open-drain pull-down enables for SCL and SDA and produces two one-cycle strobes. The launch strobe marks the point in the SCL low phase where SDA is updated. The sample strobe marks the point in the SCL high phase where SDA is captured. All durations are counted in system clock cycles and come from three packed 32-bit timing words.

The first word holds the high count and the sample point. The second holds the low count and the launch point. The third holds the bus-free interval and the START hold. The hardware adds 2 cycles to every low phase and 7 cycles to every high phase, so the effective periods are longer than the programmed counts. The high-phase counter only advances while SCL reads back high, which lets a slave stretch the clock.

The command engine presents one request at a time on a valid/ready pair. Between requests the block parks with SCL held low. After a STOP, a new START is held off until the bus-free interval has passed.

Top module: `sclgen_top`

## Requirements
- R1: While reset is applied and just after it, SCL and SDA are released and both strobes and `op_done` are low. `busy` is high and `cmd_ready` is low until the bus-free interval has elapsed.
- R2: A START (code 1) is accepted from idle only once the bus-free interval has passed. SDA is then pulled low with SCL released for max(lead,1) cycles, after which SCL is pulled low.
- R3: After a request is accepted in the parked state, SCL stays pulled low for exactly low+2 cycles. The count starts at the cycle after acceptance.
- R4: The high phase lasts high+7 cycles in which SCL reads back high. Every cycle in which a slave holds SCL low adds one cycle to the released time.
- R5: SDA is updated, and `launch_stb` pulses, at low-phase index min(xmit, low). Index 0 is the first cycle after acceptance, so the update always lands while SCL is still low. A data bit of 0 pulls SDA low, a data bit of 1 releases it, a START releases it and a STOP pulls it low.
- R6: For data requests only, SDA is captured into `rx_bit` at high-phase count min(rcv, high+6), and `sample_stb` pulses. The launch and sample strobes are never high together.
- R7: A START (code 1) issued while parked is a repeated START. It runs a full low and high phase with SDA released, then pulls SDA low for max(lead,1) cycles with SCL released, then pulls SCL low.
- R8: A STOP (code 2) runs a low phase that pulls SDA low and then a full high phase. It then releases SDA and returns to idle. `cmd_ready` stays low for the next `free` cycles, and a pending START is held off during that time.
- R9: Request code 0 is a data bit and code 3 is a no-op. In idle, data, STOP and no-op requests are consumed with no bus activity. A no-op while parked leaves SCL low and starts nothing.
- R10: `op_done` pulses for one cycle at the end of each START, data bit and STOP.
- R11: `busy` is high whenever the block is not idle or the bus-free interval is still running. `cmd_ready` is only high while parked (SCL low) or while idle and free.
- R12: With SCL released, SDA only changes as a START (pulled low, with the sequence still running) or as a STOP (released, together with `op_done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tim_high_smp | input | 32 | High count [31:16], sample point [15:0] |
| tim_low_lau | input | 32 | Low count [31:16], launch point [15:0] |
| tim_free_lead | input | 32 | Bus-free count [31:16], START hold [15:0] |
| cmd_valid | input | 1 | Request present |
| cmd_kind | input | 2 | 0 data, 1 START, 2 STOP, 3 no-op |
| cmd_bit | input | 1 | Data bit to drive (1 releases SDA) |
| cmd_ready | output | 1 | Request accepted on this cycle when valid |
| scl_in | input | 1 | SCL level read back from the bus |
| sda_in | input | 1 | SDA level read back from the bus |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| launch_stb | output | 1 | SDA update point reached |
| sample_stb | output | 1 | SDA sample point reached |
| rx_bit | output | 1 | Last sampled SDA value |
| op_done | output | 1 | Current request finished |
| busy | output | 1 | Clock generation active or bus not yet free |

## Verification
Data bits are run with random timing words and random combinations of transmitted bit, slave response and stretch length. The measured low span, released span, launch index and sample index separate errors in the +2 and +7 overheads from errors in stretch handling and in strobe placement. Directed cases set the launch and sample fields far beyond their phases, which exercises the clamping rules. A zero START hold and a zero free time cover the minimum-length edges. Repeated START, STOP followed by a held-off START, and requests that must be ignored in idle or while parked show that the sequencing of the request kinds is kept apart.

// File: rtl/sclgen_pkg.sv
`timescale 1ns/1ps
package sclgen_pkg;

    localparam int FIELD_W = 16;
    localparam int REG_W   = 2 * FIELD_W;
    localparam int EFF_W   = FIELD_W + 1;

    typedef enum logic [1:0] {
        REQ_DATA  = 2'd0,
        REQ_START = 2'd1,
        REQ_STOP  = 2'd2,
        REQ_NOP   = 2'd3
    } req_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_PARK,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic [EFF_W-1:0]   low_len;
        logic [EFF_W-1:0]   high_len;
        logic [EFF_W-1:0]   launch_at;
        logic [EFF_W-1:0]   sample_at;
        logic [FIELD_W-1:0] lead_len;
        logic [FIELD_W-1:0] free_len;
    } timing_t;

    function automatic logic [EFF_W-1:0] clip_point(
        input logic [EFF_W-1:0] point,
        input logic [EFF_W-1:0] last
    );
        return (point > last) ? last : point;
    endfunction

endpackage

// File: rtl/sclgen_cfg_decode.sv
`timescale 1ns/1ps
module sclgen_cfg_decode
    import sclgen_pkg::*;
#(
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic [REG_W-1:0] high_word,
    input  logic [REG_W-1:0] low_word,
    input  logic [REG_W-1:0] free_word,
    output timing_t          tm
);

    localparam logic [EFF_W-1:0] LOW_ADD  = EFF_W'(LOW_EXTRA);
    localparam logic [EFF_W-1:0] HIGH_ADD = EFF_W'(HIGH_EXTRA);

    logic [EFF_W-1:0] low_len;
    logic [EFF_W-1:0] high_len;

    always_comb begin
        low_len  = {1'b0, low_word[REG_W-1:FIELD_W]} + LOW_ADD;
        high_len = {1'b0, high_word[REG_W-1:FIELD_W]} + HIGH_ADD;
        tm.low_len   = low_len;
        tm.high_len  = high_len;
        // launch must land at least one cycle before SCL is released
        tm.launch_at = clip_point({1'b0, low_word[FIELD_W-1:0]}, low_len - EFF_W'(2));
        tm.sample_at = clip_point({1'b0, high_word[FIELD_W-1:0]}, high_len - EFF_W'(1));
        tm.lead_len  = free_word[FIELD_W-1:0];
        tm.free_len  = free_word[REG_W-1:FIELD_W];
    end

endmodule

// File: rtl/sclgen_free_timer.sv
`timescale 1ns/1ps
module sclgen_free_timer
    import sclgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [FIELD_W-1:0] limit,
    output logic               free_ok
);

    logic [FIELD_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            elapsed <= '0;
        end else if (elapsed < limit) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign free_ok = run && (elapsed >= limit);

endmodule

// File: rtl/sclgen_top.sv
`timescale 1ns/1ps
module sclgen_top
    import sclgen_pkg::*;
#(
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] tim_high_smp,
    input  logic [REG_W-1:0] tim_low_lau,
    input  logic [REG_W-1:0] tim_free_lead,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_bit,
    output logic             cmd_ready,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             launch_stb,
    output logic             sample_stb,
    output logic             rx_bit,
    output logic             op_done,
    output logic             busy
);

    timing_t          tm;
    phase_e           ph;
    req_e             op_q;
    logic             bit_q;
    logic [EFF_W-1:0] cnt;
    logic             free_ok;
    logic             idle;
    req_e             req;
    logic             drive_val;

    sclgen_cfg_decode #(
        .LOW_EXTRA (LOW_EXTRA),
        .HIGH_EXTRA(HIGH_EXTRA)
    ) u_decode (
        .high_word(tim_high_smp),
        .low_word (tim_low_lau),
        .free_word(tim_free_lead),
        .tm       (tm)
    );

    assign idle = (ph == PH_IDLE);

    sclgen_free_timer u_free (
        .clk    (clk),
        .rst    (rst),
        .run    (idle),
        .limit  (tm.free_len),
        .free_ok(free_ok)
    );

    assign req       = req_e'(cmd_kind);
    assign cmd_ready = (idle && free_ok) || (ph == PH_PARK);
    assign busy      = !idle || !free_ok;

    // SDA pull-down value applied at the launch point of the low phase
    always_comb begin
        case (op_q)
            REQ_DATA:  drive_val = !bit_q;
            REQ_STOP:  drive_val = 1'b1;
            default:   drive_val = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            op_q       <= REQ_DATA;
            bit_q      <= 1'b0;
            cnt        <= '0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            launch_stb <= 1'b0;
            sample_stb <= 1'b0;
            rx_bit     <= 1'b0;
            op_done    <= 1'b0;
        end else begin
            launch_stb <= 1'b0;
            sample_stb <= 1'b0;
            op_done    <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (cmd_valid && free_ok && req == REQ_START) begin
                        sda_oe <= 1'b1;
                        cnt    <= '0;
                        ph     <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if ((cnt + 1'b1) >= {1'b0, tm.lead_len}) begin
                        scl_oe  <= 1'b1;
                        op_done <= 1'b1;
                        cnt     <= '0;
                        ph      <= PH_PARK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PARK: begin
                    if (cmd_valid && req != REQ_NOP) begin
                        op_q  <= req;
                        bit_q <= cmd_bit;
                        cnt   <= '0;
                        ph    <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (cnt == tm.launch_at) begin
                        sda_oe     <= drive_val;
                        launch_stb <= 1'b1;
                    end
                    if (cnt == tm.low_len - 1'b1) begin
                        scl_oe <= 1'b0;
                        cnt    <= '0;
                        ph     <= PH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    // counter frozen while a slave holds SCL low
                    if (scl_in) begin
                        if (cnt == tm.sample_at && op_q == REQ_DATA) begin
                            rx_bit     <= sda_in;
                            sample_stb <= 1'b1;
                        end
                        if (cnt == tm.high_len - 1'b1) begin
                            cnt <= '0;
                            case (op_q)
                                REQ_START: begin
                                    sda_oe <= 1'b1;
                                    ph     <= PH_LEAD;
                                end
                                REQ_STOP: begin
                                    sda_oe  <= 1'b0;
                                    op_done <= 1'b1;
                                    ph      <= PH_IDLE;
                                end
                                default: begin
                                    scl_oe  <= 1'b1;
                                    op_done <= 1'b1;
                                    ph      <= PH_PARK;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sclgen_checker.sv
`timescale 1ns/1ps
module sclgen_checker (
    input logic clk,
    input logic rst,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_in,
    input logic launch_stb,
    input logic sample_stb,
    input logic op_done,
    input logic cmd_ready,
    input logic busy
);

    AST_LAUNCH_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        launch_stb |-> scl_oe); // R5

    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> ($past(scl_in) && !$past(scl_oe))); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && sample_stb)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done); // R10

    AST_READY_STATE: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (scl_oe || !busy)); // R11

    AST_SDA_RELEASE_IS_STOP: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> op_done); // R12

    AST_SDA_PULL_IS_START: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (busy && !cmd_ready)); // R12

endmodule

bind sclgen_top sclgen_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .scl_in    (scl_in),
    .launch_stb(launch_stb),
    .sample_stb(sample_stb),
    .op_done   (op_done),
    .cmd_ready (cmd_ready),
    .busy      (busy)
);

// File: tb/sclgen_top_tb.sv
`timescale 1ns/1ps
module sclgen_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tim_high_smp = '0;
    logic [31:0] tim_low_lau = '0;
    logic [31:0] tim_free_lead = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic        cmd_bit = 1'b0;
    logic        cmd_ready;
    logic        scl_in;
    logic        sda_in;
    logic        scl_oe;
    logic        sda_oe;
    logic        launch_stb;
    logic        sample_stb;
    logic        rx_bit;
    logic        op_done;
    logic        busy;
    logic        stretch = 1'b0;
    logic        slv_low = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int lo, hi, xm, rc, ld, fr;

    assign scl_in = !scl_oe && !stretch;
    assign sda_in = !sda_oe && !slv_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclgen_top u_dut (
        .clk(clk), .rst(rst),
        .tim_high_smp(tim_high_smp), .tim_low_lau(tim_low_lau), .tim_free_lead(tim_free_lead),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .launch_stb(launch_stb), .sample_stb(sample_stb), .rx_bit(rx_bit),
        .op_done(op_done), .busy(busy)
    );

    function automatic int e_low();  return lo + 2; endfunction
    function automatic int e_high(); return hi + 7; endfunction
    function automatic int e_lau();  return (xm >= lo + 1) ? lo : xm; endfunction
    function automatic int e_smp();  return (rc >= hi + 7) ? hi + 6 : rc; endfunction
    function automatic int e_lead(); return (ld < 1) ? 1 : ld; endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic set_cfg(input int l, input int h, input int x, input int r, input int d, input int f);
        lo = l; hi = h; xm = x; rc = r; ld = d; fr = f;
        tim_high_smp  = {h[15:0], r[15:0]};
        tim_low_lau   = {l[15:0], x[15:0]};
        tim_free_lead = {f[15:0], d[15:0]};
    endtask

    // present a request, wait for acceptance; returns at the first negedge after the accepting edge
    task automatic issue(input logic [1:0] kind, input logic b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_bit = b;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] kind, input logic b, input logic s, input int k,
                          output int c_lo, output int c_rel, output int c_rel1,
                          output int i_lau, output int i_smp, output int i_done, output logic rx);
        bit rel_seen;
        int rem;
        c_lo = 0; c_rel = 0; c_rel1 = 0; i_lau = -1; i_smp = -1; i_done = -1;
        rel_seen = 0; rem = 0;
        issue(kind, b);
        slv_low = !s;
        for (int n = 1; n < 5000; n++) begin
            if (launch_stb) i_lau = n;
            if (sample_stb) i_smp = n;
            if (op_done) i_done = n;
            if (scl_oe && !rel_seen) begin
                c_lo++;
            end else if (!scl_oe) begin
                if (op_done) break;
                if (!rel_seen) begin rel_seen = 1; rem = k; end
                else if (rem > 0) rem--;
                stretch = (rem > 0);
                c_rel++;
                if (sda_oe) c_rel1++;
            end else begin
                break;
            end
            @(negedge clk);
        end
        rx = rx_bit;
        slv_low = 1'b0;
        stretch = 1'b0;
    endtask

    task automatic do_start_idle();
        int a, b2, c, d, e, f; logic r;
        run_op(2'd1, 1'b0, 1'b1, 0, a, b2, c, d, e, f, r);
        chk_eq("R2 start hold span", b2, e_lead());
        chk_eq("R2 sda low during hold", c, e_lead());
        chk_eq("R10 start done index", f, e_lead() + 1);
        chk_eq("R3 scl pulled after start", int'(scl_oe), 1);
    endtask

    task automatic do_bit(input logic b, input logic s, input int k);
        int a, b2, c, d, e, f; logic r;
        run_op(2'd0, b, s, k, a, b2, c, d, e, f, r);
        chk_eq("R3 low span", a, e_low());
        chk_eq("R4 released span", b2, e_high() + k);
        chk_eq("R5 launch index", d, e_lau() + 2);
        chk_eq("R5 sda drive value", c, b ? 0 : e_high() + k);
        chk_eq("R6 sample index", e, e_low() + k + e_smp() + 2);
        chk_eq("R6 captured bit", int'(r), int'(b & s));
        chk_eq("R10 data done index", f, e_low() + k + e_high() + 1);
    endtask

    task automatic do_rstart();
        int a, b2, c, d, e, f; logic r;
        run_op(2'd1, 1'b0, 1'b1, 0, a, b2, c, d, e, f, r);
        chk_eq("R7 low span", a, e_low());
        chk_eq("R7 released span", b2, e_high() + e_lead());
        chk_eq("R7 sda hold span", c, e_lead());
        chk_eq("R7 no sample", e, -1);
    endtask

    task automatic do_stop();
        int a, b2, c, d, e, f; logic r;
        int fc;
        bit held;
        run_op(2'd2, 1'b0, 1'b1, 0, a, b2, c, d, e, f, r);
        chk_eq("R8 low span", a, e_low());
        chk_eq("R8 high span sda low", c, e_high());
        chk_eq("R8 done index", f, e_low() + e_high() + 1);
        chk_eq("R8 sda released", int'(sda_oe), 0);
        chk_eq("R11 busy after stop", int'(busy), fr > 0 ? 1 : 0);
        // present a START while the free interval runs; it must be held off
        cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_bit = 1'b0;
        fc = 0; held = 1;
        while (!cmd_ready && fc < 70000) begin
            if (sda_oe || scl_oe) held = 0;
            fc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk_eq("R8 free interval", fc, fr);
        chk(held, "R2 start held off", 0, 1);
    endtask

    initial begin
        int lo_r, hi_r;
        void'($urandom(32'h5EED_1234));
        set_cfg(4, 3, 2, 4, 3, 5);
        repeat (3) @(negedge clk);
        chk_eq("R1 scl released in reset", int'(scl_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 scl released", int'(scl_oe), 0);
        chk_eq("R1 sda released", int'(sda_oe), 0);
        chk_eq("R1 strobes low", int'(launch_stb | sample_stb | op_done), 0);
        chk_eq("R1 busy while free runs", int'(busy), 1);
        chk_eq("R1 not ready", int'(cmd_ready), 0);

        // R9: non-start requests in idle are consumed with no bus activity
        issue(2'd0, 1'b0);
        issue(2'd2, 1'b0);
        issue(2'd3, 1'b0);
        for (int n = 0; n < 15; n++) begin
            chk(!scl_oe && !sda_oe && !busy && !op_done, "R9 idle request ignored",
                int'({scl_oe, sda_oe, busy, op_done}), 0);
            @(negedge clk);
        end

        // directed transaction
        do_start_idle();
        do_bit(1'b0, 1'b1, 0);
        do_bit(1'b1, 1'b0, 3);
        // R9: no-op while parked
        issue(2'd3, 1'b0);
        for (int n = 0; n < e_low() + e_high() + 4; n++) begin
            chk(scl_oe && !launch_stb && !op_done && cmd_ready, "R9 park no-op",
                int'({scl_oe, launch_stb, op_done, cmd_ready}), 4'b1001);
            @(negedge clk);
        end
        do_rstart();
        do_bit(1'b1, 1'b1, 0);
        do_stop();

        // clamped points, zero hold, zero free time
        set_cfg(3, 0, 1000, 1000, 0, 0);
        do_start_idle();
        do_bit(1'b0, 1'b1, 0);
        do_bit(1'b1, 1'b1, 2);
        do_rstart();
        do_stop();

        // random timing words and bit patterns
        for (int it = 0; it < 10; it++) begin
            lo_r = $urandom_range(12, 0);
            hi_r = $urandom_range(10, 0);
            set_cfg(lo_r, hi_r, $urandom_range(lo_r + 3, 0), $urandom_range(hi_r + 9, 0),
                    $urandom_range(8, 0), $urandom_range(10, 0));
            do_start_idle();
            for (int j = 0; j < int'($urandom_range(4, 1)); j++)
                do_bit(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom_range(4, 0));
            if ($urandom_range(1, 0) == 1) begin
                do_rstart();
                do_bit(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom_range(3, 0));
            end
            do_stop();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule